// File: doc/BRIEF.md
# Ripple-Slice Arithmetic and Logic Unit

This block is a combinational arithmetic and logic unit. It is built from a row of identical one-bit slices. Every slice sees the same three-bit operation code. Each slice forms four functions of its operand bits: AND, OR, take A, take B. It also forms a full-adder sum with its incoming carry. A one-hot select, decoded once from the operation code, picks which value the slice drives onto its result bit.

Carries pass from slice to slice in ripple fashion. The block's carry input feeds the lowest slice. The carry from the top slice, together with the result bus, forms a result one bit wider than the operands. The carry output is meaningful only for the add code. It is forced to zero for every other code. The three unused codes yield an all-zero result, so the output is always fully defined. The operand width is a parameter and defaults to 8.

Top module: `alu_ripple_slice`

## Requirements
- R1: Operation code 3'b000 drives the result with the bitwise AND of operand A and operand B.
- R2: Operation code 3'b001 drives the result with the bitwise OR of operand A and operand B.
- R3: Operation code 3'b010 drives the result with operand A unchanged.
- R4: Operation code 3'b011 drives the result with operand B unchanged.
- R5: Operation code 3'b100 drives {carry_out, result} with the arithmetic sum A + B + carry_in, taken as WIDTH+1 bits.
- R6: For operation codes 3'b000 through 3'b011 the carry output is 0.
- R7: Operation codes 3'b101, 3'b110 and 3'b111 give a result of all zeros and a carry output of 0.
- R8: For every code other than 3'b100, the carry input has no effect on either output.
- R9: A carry can pass through every slice. With the add code, an all-ones A, a zero B and a carry input of 1 give an all-zero result and a carry output of 1, at any width.
- R10: The outputs are a purely combinational function of the present inputs. There is no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation select, shared by all slices |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the lowest slice (used by the add code) |
| result | output | WIDTH | Selected operation result |
| carry_out | output | 1 | Carry from the top slice for the add code, otherwise 0 |

## Verification
A four-bit copy is swept over every combination of operation code, both operands and carry input. Each output is compared with a value the bench works out arithmetically. For every code, the sweep includes vectors that differ only in the carry input; matching the expected value on both halves shows that the carry is ignored outside the add code. Sums that stop short of the top slice are separated from sums that wrap into carry_out. An eight-bit copy adds full-length propagation cases: all ones plus a carry, the two top bits added together, and the largest possible sum. These cases show whether the chain carries cleanly across every slice at the default width.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    typedef enum logic [2:0] {
        OPC_AND   = 3'b000,
        OPC_OR    = 3'b001,
        OPC_TAKEA = 3'b010,
        OPC_TAKEB = 3'b011,
        OPC_ADD   = 3'b100
    } alu_opc_e;

    // One-hot function select shared by every slice, plus carry enable
    typedef struct packed {
        logic f_and;
        logic f_or;
        logic f_take_a;
        logic f_take_b;
        logic f_sum;
        logic carry_en;
    } slice_sel_t;

    // Per-slice combinational outputs
    typedef struct packed {
        logic res;
        logic cout;
    } slice_out_t;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_slice_pkg::*;
(
    input  logic [2:0]  op_code,
    output slice_sel_t  sel
);

    slice_sel_t sel_d;

    always_comb begin
        sel_d = '0;
        unique case (op_code)
            OPC_AND:   sel_d.f_and    = 1'b1;
            OPC_OR:    sel_d.f_or     = 1'b1;
            OPC_TAKEA: sel_d.f_take_a = 1'b1;
            OPC_TAKEB: sel_d.f_take_b = 1'b1;
            OPC_ADD: begin
                sel_d.f_sum    = 1'b1;
                sel_d.carry_en = 1'b1;
            end
            default:   sel_d = '0;
        endcase
    end

    assign sel = sel_d;

    // At most one function is ever selected (guards R1-style selection and R7)
    always_comb begin
        if (!$isunknown(op_code)) begin
            assert_sel_onehot_R7: assert ($onehot0({sel.f_and, sel.f_or, sel.f_take_a,
                                                    sel.f_take_b, sel.f_sum}))
                else $error("decoder select not one-hot");
        end
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  slice_sel_t sel,
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       c_bit,
    output logic       res_bit,
    output logic       carry_bit
);

    slice_out_t out_d;

    always_comb begin
        out_d.cout = (a_bit & b_bit) | (b_bit & c_bit) | (a_bit & c_bit);
        out_d.res  = (sel.f_and    & (a_bit & b_bit))
                   | (sel.f_or     & (a_bit | b_bit))
                   | (sel.f_take_a & a_bit)
                   | (sel.f_take_b & b_bit)
                   | (sel.f_sum    & (a_bit ^ b_bit ^ c_bit));
    end

    assign res_bit   = out_d.res;
    assign carry_bit = out_d.cout;

endmodule

// File: rtl/alu_ripple_slice.sv
module alu_ripple_slice
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [2:0]       op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int CHAIN_LEN = WIDTH + 1;

    slice_sel_t           sel;
    logic [CHAIN_LEN-1:0] chain_d;
    logic [WIDTH-1:0]     result_d;

    alu_op_decoder u_dec (
        .op_code (op_code),
        .sel     (sel)
    );

    assign chain_d[0] = carry_in;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
        alu_bit_slice u_slice (
            .sel       (sel),
            .a_bit     (opnd_a[gi]),
            .b_bit     (opnd_b[gi]),
            .c_bit     (chain_d[gi]),
            .res_bit   (result_d[gi]),
            .carry_bit (chain_d[gi+1])
        );
    end

    assign result    = result_d;
    assign carry_out = sel.carry_en & chain_d[WIDTH];

    // Port-level checks against arithmetic and bitwise references
    always_comb begin
        if (!$isunknown({op_code, opnd_a, opnd_b, carry_in})) begin
            if (op_code == 3'b000)
                assert_and_R1: assert (result == (opnd_a & opnd_b)) else $error("AND mismatch");
            if (op_code == 3'b001)
                assert_or_R2: assert (result == (opnd_a | opnd_b)) else $error("OR mismatch");
            if (op_code == 3'b010)
                assert_take_a_R3: assert (result == opnd_a) else $error("take A mismatch");
            if (op_code == 3'b011)
                assert_take_b_R4: assert (result == opnd_b) else $error("take B mismatch");
            if (op_code == 3'b100)
                assert_sum_R5: assert ({carry_out, result} ==
                                       (CHAIN_LEN'(opnd_a) + CHAIN_LEN'(opnd_b) + CHAIN_LEN'(carry_in)))
                    else $error("sum mismatch");
            if (op_code[2] == 1'b0)
                assert_logic_carry_zero_R6: assert (carry_out == 1'b0) else $error("carry not zero");
            if (op_code[2] && (op_code[1:0] != 2'b00))
                assert_unused_zero_R7: assert ((result == '0) && !carry_out) else $error("unused code not zero");
        end
    end

endmodule

// File: tb/alu_ripple_slice_bench.sv
module alu_ripple_slice_bench;

    localparam int SW = 4;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [2:0]    op_s;
    logic [SW-1:0] a_s, b_s, r_s;
    logic          ci_s, co_s;

    logic [2:0]    op_l;
    logic [LW-1:0] a_l, b_l, r_l;
    logic          ci_l, co_l;

    alu_ripple_slice #(.WIDTH(SW)) u_alu_ripple_slice (
        .op_code (op_s), .opnd_a (a_s), .opnd_b (b_s),
        .carry_in (ci_s), .result (r_s), .carry_out (co_s)
    );

    alu_ripple_slice #(.WIDTH(LW)) u_alu_ripple_slice_w8 (
        .op_code (op_l), .opnd_a (a_l), .opnd_b (b_l),
        .carry_in (ci_l), .result (r_l), .carry_out (co_l)
    );

    task automatic check_small(input string tag);
        logic [SW:0] exp;
        int sum;
        case (op_s)
            3'b000: exp = {1'b0, a_s & b_s};
            3'b001: exp = {1'b0, a_s | b_s};
            3'b010: exp = {1'b0, a_s};
            3'b011: exp = {1'b0, b_s};
            3'b100: begin
                sum = int'(a_s) + int'(b_s) + int'(ci_s);
                exp = (SW+1)'(sum);
            end
            default: exp = '0;
        endcase
        checks++;
        if ({co_s, r_s} !== exp) begin
            failures++;
            $display("FAIL %s op=%b a=%h b=%h ci=%b actual=%h expected=%h",
                     tag, op_s, a_s, b_s, ci_s, {co_s, r_s}, exp);
        end
    endtask

    task automatic check_large(input string tag, input logic [LW:0] exp);
        checks++;
        if ({co_l, r_l} !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h ci=%b actual=%h expected=%h",
                     tag, a_l, b_l, ci_l, {co_l, r_l}, exp);
        end
    endtask

    task automatic drive_large(input logic [LW-1:0] a, input logic [LW-1:0] b, input logic ci);
        @(posedge clk);
        op_l = 3'b100; a_l = a; b_l = b; ci_l = ci;
        @(negedge clk);
    endtask

    initial begin
        string tag;
        op_s = '0; a_s = '0; b_s = '0; ci_s = 1'b0;
        op_l = '0; a_l = '0; b_l = '0; ci_l = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state with all-zero inputs (R1, R10)
        checks++;
        if ({co_s, r_s} !== '0 || {co_l, r_l} !== '0) begin
            failures++;
            $display("FAIL R10 idle actual=%h/%h expected=0", {co_s, r_s}, {co_l, r_l});
        end

        // Exhaustive sweep of the small configuration
        for (int op = 0; op < 8; op++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int a = 0; a < (1 << SW); a++) begin
                    for (int b = 0; b < (1 << SW); b++) begin
                        @(posedge clk);
                        op_s = 3'(op); a_s = SW'(a); b_s = SW'(b); ci_s = 1'(ci);
                        @(negedge clk);
                        case (op)
                            0: tag = "R1";
                            1: tag = "R2";
                            2: tag = "R3";
                            3: tag = "R4";
                            4: tag = "R5";
                            default: tag = "R7";
                        endcase
                        if (op < 4 && ci == 1) tag = {tag, "/R6/R8"};
                        else if (op < 4) tag = {tag, "/R6"};
                        else if (op > 4 && ci == 1) tag = {tag, "/R8"};
                        check_small(tag);
                    end
                end
            end
        end

        // Full-length propagation at the default width (R9)
        drive_large(8'hFF, 8'h00, 1'b1); check_large("R9 ones+cin", 9'h100);
        drive_large(8'h80, 8'h80, 1'b0); check_large("R9 top bits", 9'h100);
        drive_large(8'hFF, 8'hFF, 1'b1); check_large("R9 max sum", 9'h1FF);
        drive_large(8'h7F, 8'h00, 1'b1); check_large("R5 no wrap", 9'h080);
        drive_large(8'h5A, 8'hA5, 1'b0); check_large("R5 no carry", 9'h0FF);

        // Non-add code at default width ignores carry input (R8, R6)
        @(posedge clk);
        op_l = 3'b001; a_l = 8'hF0; b_l = 8'h0F; ci_l = 1'b1;
        @(negedge clk);
        check_large("R8 OR with cin", 9'h0FF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule